// File: doc/BRIEF.md
# Receive Buffer Ring Command Scheduler

This block keeps a fixed ring of receive buffers loaded into a stream-to-memory data mover. Once started, it puts one transfer command per free buffer on a valid/ready command stream, so every buffer is ready to take data before any data comes in. Each command names a buffer by its slot number, which travels as the command tag. The command also carries the buffer's address, computed as a base plus the slot number times the slot size, and the slot size as the length limit.

The mover reports each finished transfer on a separate status stream. The block writes the reported byte count and error flag into a register owned by that slot, so re-arming other buffers cannot overwrite it. A host-side request port then hands filled slots out one at a time, oldest first. A request that finds no filled slot stays pending until one fills. A buffer is re-armed only after the host confirms it has finished with the slot it holds.

Start, stop and flush controls govern the run. Flush discards every queued command and every recorded status. A flush (or the power-on reset) must come before each new start.

Top module: `ring_cmd_sched`

## Requirements
- R1: Out of reset `cmd_valid`, `host_valid` and `tag_error` are 0 and `sts_ready` is 1. No command is issued until `ctl_start` is pulsed.
- R2: After a start, the block issues one command for each free slot in ascending slot order, wrapping after the last slot. Each command has `cmd_tag` equal to the slot number, `cmd_addr` = BASE_ADDR + slot × SLOT_BYTES and `cmd_len` = SLOT_BYTES.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_tag` and `cmd_addr` stay unchanged into the next cycle.
- R4: The byte count of each status record is stored in the slot it completes. Later status records for other slots never change it, and the host receives it unchanged as `host_len`.
- R5: A `host_get` pulse returns, through a one-cycle `host_valid` pulse with `host_idx`, `host_len` and `host_err`, the oldest slot whose status has arrived. If no such slot exists, the request stays pending and is answered in the cycle after the next status record arrives.
- R6: At most one slot is held by the host. A `host_get` while a slot is held is ignored and produces no response.
- R7: `host_confirm` releases the held slot, and only then is that slot's command issued again. A `host_confirm` while no slot is held has no effect.
- R8: A status record with its error flag set still completes its slot, and the host receives `host_err` = 1 for that slot.
- R9: A status record whose tag differs from the oldest outstanding slot, or that arrives when no slot is outstanding, sets `tag_error`. The bit stays set until a flush.
- R10: After `ctl_stop`, no new command is issued. Status capture and host hand-out keep working.
- R11: `ctl_flush` returns every slot to free, drops the command on the stream and clears `tag_error` and any pending request. A `ctl_start` that follows a stop without an intervening flush is ignored.
- R12: A command is issued only for a free slot, so no more than the ring's slot count are ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_start | input | 1 | Begin issuing commands (pulse) |
| ctl_stop | input | 1 | Stop issuing new commands (pulse) |
| ctl_flush | input | 1 | Discard all commands and statuses (pulse) |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_addr | output | ADDR_W | Buffer start address |
| cmd_len | output | LEN_W | Maximum bytes for the transfer |
| cmd_tag | output | log2(NUM_SLOTS) | Slot number of the command |
| sts_valid | input | 1 | Status stream valid |
| sts_ready | output | 1 | Status stream ready (always 1) |
| sts_tag | input | log2(NUM_SLOTS) | Tag of the finished transfer |
| sts_bytes | input | LEN_W | Bytes actually written |
| sts_err | input | 1 | Transfer error flag |
| host_get | input | 1 | Request next filled slot (pulse) |
| host_confirm | input | 1 | Release the held slot (pulse) |
| host_valid | output | 1 | One-cycle response to a get |
| host_idx | output | log2(NUM_SLOTS) | Slot handed to the host |
| host_len | output | LEN_W | Stored byte count of that slot |
| host_err | output | 1 | Stored error flag of that slot |
| tag_error | output | 1 | Sticky status-order error |

## Verification
The assertions assume the mover returns a status record only for a command it has already accepted. They also assume the host does not pulse `host_get` and `host_confirm` in the same cycle. The bench's mover model therefore answers only tags it has seen accepted, in acceptance order, except for one deliberately wrong tag used for the order check. Its host tasks separate get and confirm by at least one cycle. A throttling pattern on `cmd_ready` exercises stalls, and a scoreboard predicts the command sequence and every hand-out from the requirements alone.

// File: rtl/ring_pkg.sv
package ring_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_ARMED  = 2'd1,
        SLOT_FILLED = 2'd2,
        SLOT_HELD   = 2'd3
    } slot_st_e;
endpackage

// File: rtl/ring_slot_table.sv
module ring_slot_table
    import ring_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int LEN_W     = 24,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             arm_en,
    input  logic [IDX_W-1:0] arm_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [LEN_W-1:0] fill_len,
    input  logic             fill_err,
    input  logic             hold_en,
    input  logic [IDX_W-1:0] hold_idx,
    input  logic             free_en,
    input  logic [IDX_W-1:0] free_idx,
    output slot_st_e         st_o  [NUM_SLOTS],
    output logic [LEN_W-1:0] len_o [NUM_SLOTS],
    output logic             err_o [NUM_SLOTS]
);
    typedef struct packed {
        slot_st_e         st;
        logic [LEN_W-1:0] len;
        logic             err;
    } slot_t;

    logic [NUM_SLOTS-1:0] held_vec;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr) begin
                slot_d.st  = SLOT_FREE;
                slot_d.len = '0;
                slot_d.err = 1'b0;
            end else begin
                if (arm_en && arm_idx == IDX_W'(i) && slot_q.st == SLOT_FREE)
                    slot_d.st = SLOT_ARMED;
                if (fill_en && fill_idx == IDX_W'(i) && slot_q.st == SLOT_ARMED) begin
                    slot_d.st  = SLOT_FILLED;
                    slot_d.len = fill_len;
                    slot_d.err = fill_err;
                end
                if (hold_en && hold_idx == IDX_W'(i) && slot_q.st == SLOT_FILLED)
                    slot_d.st = SLOT_HELD;
                if (free_en && free_idx == IDX_W'(i) && slot_q.st == SLOT_HELD)
                    slot_d.st = SLOT_FREE;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q.st  <= SLOT_FREE;
                slot_q.len <= '0;
                slot_q.err <= 1'b0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign st_o[i]     = slot_q.st;
        assign len_o[i]    = slot_q.len;
        assign err_o[i]    = slot_q.err;
        assign held_vec[i] = (slot_q.st == SLOT_HELD);
    end

    // R6: the host never owns two slots at once
    assert_single_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(held_vec) <= 1);

    // R4: a completion always lands on a slot that is waiting for data
    assert_fill_on_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !clr) |-> st_o[fill_idx] == SLOT_ARMED);
endmodule

// File: rtl/ring_cmd_stage.sv
module ring_cmd_stage #(
    parameter int              NUM_SLOTS  = 16,
    parameter int              ADDR_W     = 32,
    parameter int              LEN_W      = 24,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
    parameter int unsigned     SLOT_BYTES = 65536,
    localparam int             IDX_W      = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    output logic              can_load,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [IDX_W-1:0]  cmd_tag
);
    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    stage_t stg_d, stg_q;

    assign can_load = !stg_q.valid || cmd_ready;

    always_comb begin
        stg_d = stg_q;
        if (clr) begin
            stg_d.valid = 1'b0;
        end else begin
            if (stg_q.valid && cmd_ready)
                stg_d.valid = 1'b0;
            if (load_en) begin
                stg_d.valid = 1'b1;
                stg_d.tag   = load_idx;
                stg_d.addr  = BASE_ADDR + ADDR_W'(load_idx) * ADDR_W'(SLOT_BYTES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q.valid <= 1'b0;
            stg_q.tag   <= '0;
            stg_q.addr  <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign cmd_valid = stg_q.valid;
    assign cmd_tag   = stg_q.tag;
    assign cmd_addr  = stg_q.addr;
    assign cmd_len   = LEN_W'(SLOT_BYTES);

    // R3: a stalled command is held unchanged
    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !clr) |=> (cmd_valid && $stable(cmd_tag) && $stable(cmd_addr)));

    // R3: the scheduler loads only into an empty or draining stage
    assert_load_slot_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (!cmd_valid || cmd_ready));
endmodule

// File: rtl/ring_cmd_sched.sv
module ring_cmd_sched
    import ring_pkg::*;
#(
    parameter int                NUM_SLOTS  = 16,
    parameter int                ADDR_W     = 32,
    parameter int                LEN_W      = 24,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h8000_0000,
    parameter int unsigned       SLOT_BYTES = 65536,
    localparam int               IDX_W      = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic              ctl_flush,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [IDX_W-1:0]  cmd_tag,
    input  logic              sts_valid,
    output logic              sts_ready,
    input  logic [IDX_W-1:0]  sts_tag,
    input  logic [LEN_W-1:0]  sts_bytes,
    input  logic              sts_err,
    input  logic              host_get,
    input  logic              host_confirm,
    output logic              host_valid,
    output logic [IDX_W-1:0]  host_idx,
    output logic [LEN_W-1:0]  host_len,
    output logic              host_err,
    output logic              tag_error
);
    typedef struct packed {
        logic             run;
        logic             start_ok;
        logic [IDX_W-1:0] iss_ptr;
        logic [IDX_W-1:0] cmp_ptr;
        logic [IDX_W-1:0] rd_ptr;
        logic             get_pend;
        logic             held;
        logic             host_valid;
        logic [IDX_W-1:0] host_idx;
        logic [LEN_W-1:0] host_len;
        logic             host_err;
        logic             tag_err;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{
        run: 1'b0, start_ok: 1'b1, iss_ptr: '0, cmp_ptr: '0, rd_ptr: '0,
        get_pend: 1'b0, held: 1'b0, host_valid: 1'b0, host_idx: '0,
        host_len: '0, host_err: 1'b0, tag_err: 1'b0
    };

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    ctl_t ctl_d, ctl_q;

    slot_st_e         slot_st  [NUM_SLOTS];
    logic [LEN_W-1:0] slot_len [NUM_SLOTS];
    logic             slot_err [NUM_SLOTS];

    logic can_load, load_en, fill_en, hold_en, free_en;

    // Status records are always taken in the cycle they are offered.
    assign sts_ready = 1'b1;

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.host_valid = 1'b0;
        load_en          = 1'b0;
        fill_en          = 1'b0;
        hold_en          = 1'b0;
        free_en          = 1'b0;

        if (ctl_flush) begin
            ctl_d = CTL_IDLE;
        end else begin
            // run control
            if (ctl_start && ctl_q.start_ok) begin
                ctl_d.run      = 1'b1;
                ctl_d.start_ok = 1'b0;
            end
            if (ctl_stop)
                ctl_d.run = 1'b0;

            // command issue, strictly in ring order
            if (ctl_q.run && can_load && slot_st[ctl_q.iss_ptr] == SLOT_FREE) begin
                load_en       = 1'b1;
                ctl_d.iss_ptr = ring_next(ctl_q.iss_ptr);
            end

            // status capture against the oldest outstanding slot
            if (sts_valid) begin
                if (slot_st[ctl_q.cmp_ptr] == SLOT_ARMED) begin
                    fill_en       = 1'b1;
                    ctl_d.cmp_ptr = ring_next(ctl_q.cmp_ptr);
                    if (sts_tag != ctl_q.cmp_ptr)
                        ctl_d.tag_err = 1'b1;
                end else begin
                    ctl_d.tag_err = 1'b1;
                end
            end

            // host hand-out, one slot at a time
            if (!ctl_q.held) begin
                if (host_get || ctl_q.get_pend) begin
                    if (slot_st[ctl_q.rd_ptr] == SLOT_FILLED) begin
                        hold_en          = 1'b1;
                        ctl_d.held       = 1'b1;
                        ctl_d.get_pend   = 1'b0;
                        ctl_d.host_valid = 1'b1;
                        ctl_d.host_idx   = ctl_q.rd_ptr;
                        ctl_d.host_len   = slot_len[ctl_q.rd_ptr];
                        ctl_d.host_err   = slot_err[ctl_q.rd_ptr];
                    end else begin
                        ctl_d.get_pend = 1'b1;
                    end
                end
            end else if (host_confirm) begin
                free_en      = 1'b1;
                ctl_d.held   = 1'b0;
                ctl_d.rd_ptr = ring_next(ctl_q.rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_IDLE;
        else        ctl_q <= ctl_d;
    end

    ring_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .LEN_W     (LEN_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl_flush),
        .arm_en   (load_en),
        .arm_idx  (ctl_q.iss_ptr),
        .fill_en  (fill_en),
        .fill_idx (ctl_q.cmp_ptr),
        .fill_len (sts_bytes),
        .fill_err (sts_err),
        .hold_en  (hold_en),
        .hold_idx (ctl_q.rd_ptr),
        .free_en  (free_en),
        .free_idx (ctl_q.rd_ptr),
        .st_o     (slot_st),
        .len_o    (slot_len),
        .err_o    (slot_err)
    );

    ring_cmd_stage #(
        .NUM_SLOTS  (NUM_SLOTS),
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .BASE_ADDR  (BASE_ADDR),
        .SLOT_BYTES (SLOT_BYTES)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctl_flush),
        .load_en   (load_en),
        .load_idx  (ctl_q.iss_ptr),
        .can_load  (can_load),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .cmd_tag   (cmd_tag)
    );

    assign host_valid = ctl_q.host_valid;
    assign host_idx   = ctl_q.host_idx;
    assign host_len   = ctl_q.host_len;
    assign host_err   = ctl_q.host_err;
    assign tag_error  = ctl_q.tag_err;

    // R12: a command on the stream belongs to a slot marked as armed
    assert_cmd_slot_armed_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> slot_st[cmd_tag] == SLOT_ARMED);

    // R5: a hand-out always names the slot the host now holds
    assert_host_slot_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> slot_st[host_idx] == SLOT_HELD);

    // R9: the order error stays until a flush
    assert_tag_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_error && !ctl_flush) |=> tag_error);

    // R10: with the run stopped and the stream idle, no command appears
    assert_no_issue_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !cmd_valid) |=> !cmd_valid);

    // R11: a flush empties the command stream
    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_flush |=> (!cmd_valid && !tag_error && !host_valid));
endmodule

// File: tb/ring_cmd_sched_bench.sv
module ring_cmd_sched_bench;
    localparam int          NS    = 16;
    localparam int          AW    = 32;
    localparam int          LW    = 24;
    localparam int          IW    = 4;
    localparam logic [31:0] BASE  = 32'h8000_0000;
    localparam int unsigned SBYTE = 65536;

    typedef struct {
        int idx;
        int len;
        int err;
    } grant_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_start = 0, ctl_stop = 0, ctl_flush = 0;
    logic          cmd_valid, cmd_ready = 0;
    logic [AW-1:0] cmd_addr;
    logic [LW-1:0] cmd_len;
    logic [IW-1:0] cmd_tag;
    logic          sts_valid = 0, sts_ready;
    logic [IW-1:0] sts_tag = '0;
    logic [LW-1:0] sts_bytes = '0;
    logic          sts_err = 0;
    logic          host_get = 0, host_confirm = 0;
    logic          host_valid;
    logic [IW-1:0] host_idx;
    logic [LW-1:0] host_len;
    logic          host_err, tag_error;

    always #10 clk = ~clk;

    ring_cmd_sched #(
        .NUM_SLOTS(NS), .ADDR_W(AW), .LEN_W(LW), .BASE_ADDR(BASE), .SLOT_BYTES(SBYTE)
    ) u_ring_cmd_sched (
        .clk(clk), .rst_n(rst_n),
        .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_flush(ctl_flush),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_tag(cmd_tag),
        .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_tag(sts_tag),
        .sts_bytes(sts_bytes), .sts_err(sts_err),
        .host_get(host_get), .host_confirm(host_confirm),
        .host_valid(host_valid), .host_idx(host_idx), .host_len(host_len),
        .host_err(host_err), .tag_error(tag_error)
    );

    int     n_cmp = 0, n_mis = 0;
    int     n_acc = 0, n_host = 0;
    bit     stall_en = 0, done = 0;
    int     rdy_cnt = 0;
    int     exp_cmd_q[$];
    grant_t exp_host_q[$];
    bit     prev_stall = 0;
    int     prev_tag = 0;
    logic [AW-1:0] prev_addr = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 ctl_start = 1;
        @(posedge clk); #1 ctl_start = 0;
    endtask
    task automatic pulse_stop();
        @(posedge clk); #1 ctl_stop = 1;
        @(posedge clk); #1 ctl_stop = 0;
    endtask
    task automatic pulse_flush();
        @(posedge clk); #1 ctl_flush = 1;
        @(posedge clk); #1 ctl_flush = 0;
    endtask
    task automatic do_get();
        @(posedge clk); #1 host_get = 1;
        @(posedge clk); #1 host_get = 0;
    endtask
    task automatic do_confirm();
        @(posedge clk); #1 host_confirm = 1;
        @(posedge clk); #1 host_confirm = 0;
    endtask
    task automatic send_status(input int tag, input int bytes, input bit err);
        @(posedge clk); #1;
        sts_valid = 1; sts_tag = IW'(tag); sts_bytes = LW'(bytes); sts_err = err;
        @(posedge clk); #1 sts_valid = 0;
    endtask
    task automatic expect_grant(input int idx, input int len, input int err);
        grant_t g;
        g.idx = idx; g.len = len; g.err = err;
        exp_host_q.push_back(g);
    endtask

    // command ready pattern: every third cycle stalls when throttling
    always @(posedge clk) begin
        #1;
        rdy_cnt++;
        cmd_ready = stall_en ? (rdy_cnt % 3 != 0) : 1'b1;
    end

    // command monitor (R2, R3, R12)
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(cmd_valid && int'(cmd_tag) == prev_tag && cmd_addr == prev_addr,
                    "R3", longint'(cmd_tag), longint'(prev_tag));
            end
            prev_stall = cmd_valid && !cmd_ready;
            prev_tag   = int'(cmd_tag);
            prev_addr  = cmd_addr;
            if (cmd_valid && cmd_ready) begin
                n_acc++;
                if (exp_cmd_q.size() == 0) begin
                    chk(0, "R12 unexpected command", longint'(cmd_tag), -1);
                end else begin
                    int et;
                    et = exp_cmd_q.pop_front();
                    chk(int'(cmd_tag) == et, "R2 tag", longint'(cmd_tag), et);
                    chk(cmd_addr == BASE + AW'(et) * AW'(SBYTE), "R2 addr",
                        longint'(cmd_addr), longint'(BASE + AW'(et) * AW'(SBYTE)));
                    chk(cmd_len == LW'(SBYTE), "R2 len", longint'(cmd_len), SBYTE);
                end
            end
        end
    end

    // host monitor (R4, R5, R8)
    always @(negedge clk) begin
        if (rst_n && host_valid) begin
            n_host++;
            if (exp_host_q.size() == 0) begin
                chk(0, "R6 unexpected grant", longint'(host_idx), -1);
            end else begin
                grant_t g;
                g = exp_host_q.pop_front();
                chk(int'(host_idx) == g.idx, "R5 idx", longint'(host_idx), g.idx);
                chk(int'(host_len) == g.len, "R4 len", longint'(host_len), g.len);
                chk(int'(host_err) == g.err, "R8 err", longint'(host_err), g.err);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int snap;
        cycles(3);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
        chk(host_valid == 0, "R1 host_valid", host_valid, 0);
        chk(tag_error == 0, "R1 tag_error", tag_error, 0);
        chk(sts_ready == 1, "R1 sts_ready", sts_ready, 1);
        cycles(10);
        chk(n_acc == 0, "R1 no command before start", n_acc, 0);

        // R2/R3: full ring issued under a throttled stream
        stall_en = 1;
        for (int k = 0; k < NS; k++) exp_cmd_q.push_back(k);
        pulse_start();
        cycles(80);
        chk(exp_cmd_q.size() == 0, "R2 all issued", exp_cmd_q.size(), 0);
        stall_en = 0;
        cycles(20);
        chk(n_acc == NS, "R12 no extra command", n_acc, NS);

        // R5: pending get answered by a later status
        do_get();
        cycles(8);
        chk(n_host == 0, "R5 pending", n_host, 0);
        expect_grant(0, 100, 0);
        send_status(0, 100, 0);
        cycles(4);
        chk(n_host == 1, "R5 served", n_host, 1);

        send_status(1, 200, 0);
        send_status(2, 300, 1);

        // R6: get while holding is ignored
        do_get();
        cycles(6);
        chk(n_host == 1, "R6 ignored get", n_host, 1);

        // R7: confirm re-arms slot 0
        exp_cmd_q.push_back(0);
        do_confirm();
        cycles(6);
        chk(n_acc == NS + 1, "R7 reissue", n_acc, NS + 1);

        expect_grant(1, 200, 0);
        do_get();
        cycles(4);
        exp_cmd_q.push_back(1);
        do_confirm();
        expect_grant(2, 300, 1);   // R8 error flag carried to host
        do_get();
        cycles(4);
        chk(n_host == 3, "R8 grant count", n_host, 3);
        exp_cmd_q.push_back(2);
        do_confirm();
        cycles(6);

        // R4: lengths kept per slot across re-armed transfers
        for (int k = 3; k < NS; k++) send_status(k, 16 * k + 7, 0);
        for (int k = 0; k < 3; k++) send_status(k, 1000 + k, 0);
        for (int j = 0; j < NS; j++) begin
            int k;
            k = (j + 3) % NS;
            expect_grant(k, (k >= 3) ? 16 * k + 7 : 1000 + k, 0);
            do_get();
            cycles(3);
            exp_cmd_q.push_back(k);
            do_confirm();
            cycles(3);
        end
        cycles(6);
        chk(exp_host_q.size() == 0, "R4 all grants seen", exp_host_q.size(), 0);
        chk(exp_cmd_q.size() == 0, "R7 all reissued", exp_cmd_q.size(), 0);

        // R7: confirm with nothing held
        snap = n_acc;
        do_confirm();
        cycles(10);
        chk(n_acc == snap, "R7 stray confirm", n_acc, snap);

        // R9: wrong tag against oldest outstanding slot (3)
        send_status(9, 50, 0);
        @(negedge clk);
        chk(tag_error == 1, "R9 set", tag_error, 1);
        cycles(5);
        @(negedge clk);
        chk(tag_error == 1, "R9 sticky", tag_error, 1);

        // R10: stop, hand-out continues, no reissue
        pulse_stop();
        expect_grant(3, 50, 0);
        do_get();
        cycles(3);
        snap = n_acc;
        do_confirm();
        cycles(10);
        chk(n_acc == snap, "R10 no command after stop", n_acc, snap);
        chk(exp_host_q.size() == 0, "R10 grant after stop", exp_host_q.size(), 0);

        // R11: restart without flush ignored
        pulse_start();
        cycles(10);
        chk(n_acc == snap, "R11 start needs flush", n_acc, snap);

        // R11: flush then start issues the whole ring again
        pulse_flush();
        @(negedge clk);
        chk(tag_error == 0, "R11 tag_error cleared", tag_error, 0);
        chk(cmd_valid == 0, "R11 stream empty", cmd_valid, 0);
        for (int k = 0; k < NS; k++) exp_cmd_q.push_back(k);
        pulse_start();
        cycles(40);
        chk(n_acc == snap + NS, "R11 full restart", n_acc, snap + NS);
        chk(exp_cmd_q.size() == 0, "R2 restart order", exp_cmd_q.size(), 0);

        summary();
    end
endmodule